// File: doc/BRIEF.md
# Alternating-Compare PWM Timer Channel

This block is one counter channel that makes a pulse-width-modulated waveform from two compare values used in turn. One compare value sets how long the output stays at its first level and the other sets how long it stays at the second level. On every match the output level flips and the other compare value takes over. Each compare value has a shadow (preload) value. A compare value is refreshed from its shadow when the *other* compare value matches, so software can change the period and the duty cycle without tearing a cycle in half.

Counting advances only on cycles where `cnt_en` is high, so any prescaler sits outside the block. Software reaches eight word-wide locations through a write strobe and a combinational read port. Hardware sets the match and overflow flags, and software clears them by writing ones. The channel has three states:

- `ST_STOP`: idle, counter at zero, output low.
- `ST_PHA`: compare A is active.
- `ST_PHB`: compare B is active.

The state transitions are:

- **start**: `ST_STOP` to the first phase. Up mode goes to `ST_PHA`; down mode goes to `ST_PHB`. If that first phase's compare is zero, the channel enters the other phase with the output high.
- **switch**: `ST_PHA`↔`ST_PHB`, taken on a match unless the incoming phase's refreshed compare is zero.
- **halt**: any phase back to `ST_STOP` when the mode field reads stop.

Top module: `pwmtmr_ch`

## Requirements
- R1: After reset, every one of the eight read locations returns 0, and `pwm_out`, `pwm_oe`, `flags` and `irq` are all 0.
- R2: Mode up with reinit, load 0 and nonzero compares A=a and B=b. Counting every cycle, the output is low for exactly a cycles, then high for exactly b cycles, and this repeats.
- R3: Mode down with reinit and load L. The counter counts down from L, and the first phase is B. The output is low for L−B cycles, then high for L−A cycles.
- R4: A match of A copies shadow B into compare B, and a match of B copies shadow A into compare A. Writing a shadow leaves the live compare unchanged until that point, and the new widths apply afterwards.
- R5: When a phase's compare is zero, that phase is skipped and the output does not glitch. Shadow and compare B at 0 hold the output low; shadow and compare A at 0 hold it high from the cycle after start.
- R6: With reinit clear, a match toggles the output but the counter keeps counting. An up count wraps from all-ones to zero and sets the overflow flag.
- R7: Control bit 3 inverts the output level at the pin. When bit 3 is clear, the level passes through unchanged.
- R8: `pwm_oe` follows control bit 4. While bit 4 is clear, `pwm_out` stays 0.
- R9: Writing control with bit 5 set drives the output flag low at that write's clock edge. Bit 5 is not stored and reads back 0.
- R10: The status word at address 6 is sticky. Its bits are:
  - bit 0: any match
  - bit 1: match of A
  - bit 2: match of B
  - bit 3: overflow

  Writing a 1 to a bit clears that bit only.
- R11: If a status bit is set by hardware and cleared by software on the same edge, it ends up set.
- R12: `irq` is high exactly when some status bit is set and its enable bit, in the same position at address 7, is also set.
- R13: Mode field control[1:0] is 00 stop, 01 up, 10 down, and 11 stop.
  - Stopping clears the counter to 0 and the output to low one edge after the write, and ticks are ignored while stopped.
  - Starting loads the counter with the value written at address 5. Reading address 5 returns the counter.
- R14: While `cnt_en` is low, the counter and the output hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count tick; the counter advances only when high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1/2 compare A/B, 3/4 shadow A/B, 5 load, 6 status clear, 7 irq enable |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 3 | Read address: same map, except 5 returns the counter and 6 the status |
| rd_data | output | WIDTH | Combinational read data |
| pwm_out | output | 1 | Output pin level after polarity and enable |
| pwm_oe | output | 1 | Output-enable for the pin |
| flags | output | 4 | Sticky status bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs with an 8-bit counter and sweeps every pair of compare values from 1 to 5, measuring the high and low run lengths. A design that swaps the phases, adds an extra cycle on reinit or loses a toggle shows the wrong widths. Targeted cases cover the following:

- **Zero-compare skip:** a design without it would flicker for one cycle or stall until the counter wraps.
- **Shadow refresh during a run:** an early copy would change the live compare at once, and a missing copy would never adopt the new widths.
- **Reinit disabled:** the low run must be the 254-cycle wrap, not the programmed value.
- **Set-versus-clear collision:** the clear is timed onto the exact edge of a match, so a design where the clear wins ends with a zero flag.

// File: rtl/pwmtmr_pkg.sv
package pwmtmr_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_UP   = 2'd1,
        MODE_DOWN = 2'd2,
        MODE_HALT = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_PHA  = 2'd1,
        ST_PHB  = 2'd2
    } phase_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
    localparam logic [ADDR_W-1:0] A_PREA = 3'd3;
    localparam logic [ADDR_W-1:0] A_PREB = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd6;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd7;

    localparam int NFLAG  = 4;
    localparam int FL_ANY = 0;
    localparam int FL_A   = 1;
    localparam int FL_B   = 2;
    localparam int FL_OVF = 3;

    localparam int CB_REINIT = 2;
    localparam int CB_INV    = 3;
    localparam int CB_OE     = 4;
    localparam int CB_FORCE  = 5;
    localparam int CTRL_W    = CB_FORCE + 1;

endpackage

// File: rtl/pwmtmr_regs.sv
module pwmtmr_regs
    import pwmtmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              hit_a,
    input  logic              hit_b,
    output cnt_mode_e         mode,
    output logic              reinit,
    output logic              inv,
    output logic              oe,
    output logic              force_pulse,
    output logic [WIDTH-1:0]  cmp_a,
    output logic [WIDTH-1:0]  cmp_b,
    output logic [WIDTH-1:0]  pre_a,
    output logic [WIDTH-1:0]  pre_b,
    output logic [WIDTH-1:0]  load_val,
    output logic [NFLAG-1:0]  irq_en
);

    logic wr_ctrl, wr_cmpa, wr_cmpb;

    assign wr_ctrl     = wr_en && (wr_addr == A_CTRL);
    assign wr_cmpa     = wr_en && (wr_addr == A_CMPA);
    assign wr_cmpb     = wr_en && (wr_addr == A_CMPB);
    assign force_pulse = wr_ctrl && wr_data[CB_FORCE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= MODE_STOP;
            reinit   <= 1'b0;
            inv      <= 1'b0;
            oe       <= 1'b0;
            pre_a    <= '0;
            pre_b    <= '0;
            load_val <= '0;
            irq_en   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    mode   <= cnt_mode_e'(wr_data[1:0]);
                    reinit <= wr_data[CB_REINIT];
                    inv    <= wr_data[CB_INV];
                    oe     <= wr_data[CB_OE];
                end
                A_PREA:  pre_a    <= wr_data;
                A_PREB:  pre_b    <= wr_data;
                A_CNT:   load_val <= wr_data;
                A_IEN:   irq_en   <= wr_data[NFLAG-1:0];
                default: ;
            endcase
        end
    end

    // Live compares: a software write wins over the hardware refresh.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_a <= '0;
            cmp_b <= '0;
        end else begin
            if (wr_cmpa)    cmp_a <= wr_data;
            else if (hit_b) cmp_a <= pre_a;
            if (wr_cmpb)    cmp_b <= wr_data;
            else if (hit_a) cmp_b <= pre_b;
        end
    end

    // R4
    reload_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && !wr_cmpb) |=> (cmp_b == $past(pre_b)));
    // R4
    reload_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b && !wr_cmpa) |=> (cmp_a == $past(pre_a)));

endmodule

// File: rtl/pwmtmr_core.sv
module pwmtmr_core
    import pwmtmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  cnt_mode_e        mode,
    input  logic             reinit,
    input  logic             force_low,
    input  logic [WIDTH-1:0] cmp_a,
    input  logic [WIDTH-1:0] cmp_b,
    input  logic [WIDTH-1:0] pre_a,
    input  logic [WIDTH-1:0] pre_b,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] cnt_q,
    output logic             oflag_q,
    output logic             hit_a,
    output logic             hit_b,
    output logic             ovf
);

    phase_e           st_q, st_d, first_ph;
    logic             running, up, in_run, hit, skip, first_zero;
    logic [WIDTH-1:0] nxt, act;

    always_comb begin
        running    = (mode == MODE_UP) || (mode == MODE_DOWN);
        up         = (mode == MODE_UP);
        in_run     = (st_q != ST_STOP) && running;
        nxt        = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        act        = (st_q == ST_PHA) ? cmp_a : cmp_b;
        hit        = in_run && tick && (nxt == act);
        hit_a      = hit && (st_q == ST_PHA);
        hit_b      = hit && (st_q == ST_PHB);
        ovf        = in_run && tick && (up ? (&cnt_q) : (cnt_q == '0));
        skip       = (((st_q == ST_PHA) ? pre_b : pre_a) == '0);
        first_zero = up ? (cmp_a == '0) : (cmp_b == '0);
        first_ph   = (up ^ first_zero) ? ST_PHA : ST_PHB;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOP: if (running) st_d = first_ph;
            ST_PHA: begin
                if (!running)          st_d = ST_STOP;
                else if (hit && !skip) st_d = ST_PHB;
            end
            ST_PHB: begin
                if (!running)          st_d = ST_STOP;
                else if (hit && !skip) st_d = ST_PHA;
            end
            default: st_d = ST_STOP;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_d;
    end

    // Counter and output flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            oflag_q <= 1'b0;
        end else if (!running) begin
            cnt_q   <= '0;
            oflag_q <= 1'b0;
        end else if (st_q == ST_STOP) begin
            cnt_q   <= load_val;
            oflag_q <= first_zero;
        end else begin
            if (tick) cnt_q <= (hit && reinit) ? load_val : nxt;
            if (force_low)         oflag_q <= 1'b0;
            else if (hit && !skip) oflag_q <= ~oflag_q;
        end
    end

    // R13
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (cnt_q == '0 && !oflag_q));
    // R14
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && !tick) |=> $stable(cnt_q));
    // R2
    toggle_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !skip && !force_low) |=> (oflag_q != $past(oflag_q)));
    // R9
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_low && in_run) |=> !oflag_q);
    // R5
    skip_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && skip && !force_low) |=> $stable(oflag_q));

endmodule

// File: rtl/pwmtmr_flags.sv
module pwmtmr_flags
    import pwmtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_a,
    input  logic              hit_b,
    input  logic              ovf,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NFLAG-1:0]  wr_bits,
    input  logic [NFLAG-1:0]  irq_en,
    output logic [NFLAG-1:0]  flags,
    output logic              irq
);

    logic [NFLAG-1:0] set, clr;

    always_comb begin
        set         = '0;
        set[FL_ANY] = hit_a | hit_b;
        set[FL_A]   = hit_a;
        set[FL_B]   = hit_b;
        set[FL_OVF] = ovf;
        clr         = (wr_en && (wr_addr == A_FLAG)) ? wr_bits : '0;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        logic q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= set[i] | (q & ~clr[i]);
        end
        assign flags[i] = q;

        // R10
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q && !clr[i]) |=> q);
        // R11
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q);
    end

    assign irq = |(flags & irq_en);

endmodule

// File: rtl/pwmtmr_ch.sv
module pwmtmr_ch
    import pwmtmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [2:0]        rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    output logic              pwm_out,
    output logic              pwm_oe,
    output logic [3:0]        flags,
    output logic              irq
);

    localparam int CTRL_PAD = WIDTH - (CTRL_W - 1);

    cnt_mode_e        mode;
    logic             reinit, inv, oe, force_pulse, oflag, hit_a, hit_b, ovf;
    logic [WIDTH-1:0] cmp_a, cmp_b, pre_a, pre_b, load_val, cnt;
    logic [NFLAG-1:0] irq_en, flags_w;

    pwmtmr_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hit_a(hit_a), .hit_b(hit_b), .mode(mode),
        .reinit(reinit), .inv(inv), .oe(oe), .force_pulse(force_pulse),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .pre_a(pre_a), .pre_b(pre_b),
        .load_val(load_val), .irq_en(irq_en)
    );

    pwmtmr_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(cnt_en), .mode(mode),
        .reinit(reinit), .force_low(force_pulse), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .pre_a(pre_a), .pre_b(pre_b), .load_val(load_val),
        .cnt_q(cnt), .oflag_q(oflag), .hit_a(hit_a), .hit_b(hit_b), .ovf(ovf)
    );

    pwmtmr_flags u_flags (
        .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b), .ovf(ovf),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_bits(wr_data[NFLAG-1:0]),
        .irq_en(irq_en), .flags(flags_w), .irq(irq)
    );

    assign flags   = flags_w;
    assign pwm_oe  = oe;
    assign pwm_out = oe & (oflag ^ inv);

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: rd_data = {{CTRL_PAD{1'b0}}, oe, inv, reinit, mode};
            A_CMPA: rd_data = cmp_a;
            A_CMPB: rd_data = cmp_b;
            A_PREA: rd_data = pre_a;
            A_PREB: rd_data = pre_b;
            A_CNT:  rd_data = cnt;
            A_FLAG: rd_data = {{(WIDTH-NFLAG){1'b0}}, flags_w};
            A_IEN:  rd_data = {{(WIDTH-NFLAG){1'b0}}, irq_en};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: tb/pwmtmr_ch_tb.sv
`timescale 1ns/1ps
module pwmtmr_ch_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, cnt_en, wr_en;
    logic [2:0]   wr_addr, rd_addr;
    logic [W-1:0] wr_data, rd_data;
    logic         pwm_out, pwm_oe, irq;
    logic [3:0]   flags;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pwmtmr_ch #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
        .flags(flags), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; captured at the next posedge; returns at the following negedge.
    task automatic wr(input int a, input int d);
        wr_en   = 1'b1;
        wr_addr = a[2:0];
        wr_data = d[W-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_addr = a[2:0];
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic setup(input int a, input int b);
        wr(0, 0);
        wr(1, a); wr(2, b); wr(3, a); wr(4, b);
    endtask

    task automatic measure(output int hi, output int lo);
        int g;
        g = 0; hi = 0; lo = 0;
        while (pwm_out  && g < 1000) begin @(negedge clk); g++; end
        while (!pwm_out && g < 1000) begin @(negedge clk); g++; end
        while (pwm_out  && g < 2000) begin hi++; @(negedge clk); g++; end
        while (!pwm_out && g < 2000) begin lo++; @(negedge clk); g++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int v, v2, hi, lo, bad;
        rst_n = 1'b0; cnt_en = 1'b1; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin rd(a, v); chk("R1 read", v, 0); end
        chk("R1 pins", {pwm_out, pwm_oe, irq, flags}, 0);

        // R2 sweep, up mode, reinit, oe
        for (int a = 1; a <= 5; a++) begin
            for (int b = 1; b <= 5; b++) begin
                setup(a, b);
                wr(0, 'h15);
                measure(hi, lo);
                chk("R2 high", hi, b);
                chk("R2 low", lo, a);
            end
        end

        // R7 inverted polarity
        for (int a = 1; a <= 4; a++) begin
            setup(a, 6 - a);
            wr(0, 'h1D);
            measure(hi, lo);
            chk("R7 high", hi, a);
            chk("R7 low", lo, 6 - a);
        end

        // R3 down mode from load 10
        setup(4, 7);
        wr(5, 10);
        wr(0, 'h16);
        measure(hi, lo);
        chk("R3 high", hi, 6);
        chk("R3 low", lo, 3);
        wr(0, 0);
        wr(5, 0);

        // R4 shadow refresh while running
        setup(5, 3);
        wr(0, 'h15);
        repeat (12) @(negedge clk);
        wr(3, 2); wr(4, 4);
        rd(1, v);  chk("R4 cmpA unchanged", v, 5);
        rd(2, v2); chk("R4 cmpB unchanged", v2, 3);
        repeat (30) @(negedge clk);
        measure(hi, lo);
        chk("R4 new high", hi, 4);
        chk("R4 new low", lo, 2);

        // R5 zero duty
        setup(4, 0);
        wr(6, 'hF);
        wr(0, 'h15);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            if (pwm_out) bad++;
            @(negedge clk);
        end
        chk("R5 0pct", bad, 0);
        rd(6, v);
        chk("R5 matches still flagged", v & 'h3, 'h3);
        // R5 full duty
        setup(0, 4);
        wr(0, 'h15);
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            if (!pwm_out) bad++;
            @(negedge clk);
        end
        chk("R5 100pct", bad, 0);

        // R9 force low
        setup(5, 5);
        wr(0, 'h15);
        while (!pwm_out) @(negedge clk);
        wr(0, 'h35);
        chk("R9 forced low", pwm_out, 0);
        rd(0, v);
        chk("R9 force not stored", v, 'h15);

        // R13 stop clears and ignores ticks
        wr(0, 0);
        @(negedge clk);
        rd(5, v);
        chk("R13 counter zero", v, 0);
        chk("R13 output low", pwm_out, 0);
        repeat (5) @(negedge clk);
        rd(5, v);
        chk("R13 ticks ignored", v, 0);
        // R13 reserved code 11 also stops
        wr(0, 'h15);
        repeat (3) @(negedge clk);
        wr(0, 'h13);
        @(negedge clk);
        rd(5, v);
        chk("R13 code 11 stops", v, 0);
        // R13 start loads load value
        setup(20, 20);
        wr(5, 7);
        wr(0, 'h15);
        @(negedge clk);
        rd(5, v);
        chk("R13 start loads", v, 7);
        wr(0, 0);
        wr(5, 0);

        // R14 cnt_en hold
        setup(50, 50);
        wr(0, 'h15);
        cnt_en = 1'b0;
        @(negedge clk);
        rd(5, v);
        repeat (5) @(negedge clk);
        rd(5, v2);
        chk("R14 held", v2, v);
        cnt_en = 1'b1;
        @(negedge clk);
        rd(5, v2);
        chk("R14 resumes", v2, v + 1);

        // R8 output enable
        setup(3, 3);
        wr(0, 'h05);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            if (pwm_out || pwm_oe) bad++;
            @(negedge clk);
        end
        chk("R8 disabled pin", bad, 0);
        wr(0, 'h15);
        chk("R8 oe high", pwm_oe, 1);

        // R6 reinit off: wrap and overflow
        setup(3, 5);
        wr(6, 'hF);
        wr(0, 'h11);
        measure(hi, lo);
        chk("R6 high", hi, 2);
        chk("R6 low wrap", lo, 254);
        wr(0, 0);
        rd(6, v);
        chk("R6 R10 flags", v, 'hF);

        // R12 interrupt gating, R10 selective clear
        wr(7, 'h8);
        chk("R12 irq on", irq, 1);
        wr(7, 'h0);
        chk("R12 irq masked", irq, 0);
        wr(7, 'h8);
        wr(6, 'h8);
        chk("R12 irq after clear", irq, 0);
        rd(6, v);
        chk("R10 selective clear", v, 'h7);
        wr(6, 'hF);
        rd(6, v);
        chk("R10 all cleared", v, 0);
        wr(7, 0);

        // R11 set and clear on the same edge
        setup(3, 50);
        wr(6, 'hF);
        wr(0, 'h15);
        repeat (3) @(negedge clk);
        wr(6, 'h3);
        rd(6, v);
        chk("R11 set wins", v, 'h3);
        wr(0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule